// File: doc/BRIEF.md
# Split Read/Write Window Mapper

This block sits between an 8-bit CPU with a 16-bit address bus and a 20-bit memory space for video and expansion storage. The top 4 KB of CPU space (0xF000 to 0xFFFF) is a window. Each access through the window is redirected to one 4 KB bank of the extended space. Software picks the bank that reads use and the bank that writes use in two separate 8-bit registers. Because of this, a loop can read from one bank and write into another without reloading anything between bytes. In the extended space, the upper half holds nonvolatile memory and the lower half holds the 512 KB of video RAM.

CPU addresses below the window go to main RAM. There is one exception after reset, when a boot overlay is active. While the overlay is on, memory reads below the window are served from nonvolatile memory, and memory writes still land in main RAM. This lets the start-up code copy an image into RAM underneath itself. Software then turns the overlay off by writing to a control port.

All three registers sit on consecutive I/O ports and can be read back. Address translation and the chip selects are combinational from the CPU strobes and the register state. Register writes take effect at the clock edge during the I/O write.

Top module: `split_window_mapper`

## Requirements
- R1: For every access inside the window, ext_addr[11:0] equals cpu_addr[11:0].
- R2: A memory read inside the window drives ext_addr[19:12] with the read-bank register, which is I/O port base+0 (base 0x40).
- R3: A memory write inside the window drives ext_addr[19:12] with the write-bank register, which is I/O port base+1.
- R4: Inside the window, vram_sel is asserted when ext_addr[19] is 0 and nvm_sel is asserted when ext_addr[19] is 1.
- R5: With the overlay off, a memory access below 0xF000 asserts ram_sel and drives ext_addr as cpu_addr zero-extended to 20 bits.
- R6: After reset the overlay is on. A memory read below 0xF000 then asserts nvm_sel and drives ext_addr = {4'h8, cpu_addr}.
- R7: While the overlay is on, a memory write below 0xF000 still asserts ram_sel, with ext_addr = {4'h0, cpu_addr}.
- R8: Bit 0 of the control register (port base+2) is the overlay enable. Writing a value with bit 0 = 0 turns the overlay off, and writing a value with bit 0 = 1 turns it back on.
- R9: An I/O read of ports base+0..base+2 returns the last value written to that register. After reset these read 0x00, 0x00 and 0x01. data_out is 0 at all other times.
- R10: No select is asserted unless mreq_n is low and rd_n or wr_n is low. At most one of ram_sel, vram_sel and nvm_sel is high at any time.
- R11: While the overlay is on, the window keeps mapping through the bank registers.
- R12: An I/O write to a port outside base+0..base+2 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address; low 8 bits form the I/O port number |
| mreq_n | input | 1 | Memory request strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| data_in | input | 8 | CPU write data |
| data_out | output | 8 | Register read-back data, zero when not read |
| ext_addr | output | 20 | Translated memory address |
| ram_sel | output | 1 | Main RAM select |
| vram_sel | output | 1 | Video RAM select |
| nvm_sel | output | 1 | Nonvolatile memory select |

## Verification
The main translation is tested with a table of accesses made after the read bank and the write bank are loaded with different values, one below 0x80 and one at or above it. Window reads and writes at the window edges (0xF000, 0xFFFF) show whether the strobe picks the correct bank and whether the offset passes through unchanged. Accesses just below the window and at 0x0000 separate window decode from main-RAM decode. Further directed runs cover these cases:
- banks 0x7F and 0x80, which locate the boundary between video RAM and nonvolatile memory;
- overlay reads against overlay writes, before and after the control write;
- a write to a neighbouring port;
- idle and I/O cycles, to check that no memory select appears.

// File: rtl/swm_pkg.sv
package swm_pkg;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_RAM  = 2'd1,
    TGT_VRAM = 2'd2,
    TGT_NVM  = 2'd3
  } tgt_e;

  // register order on the I/O ports, relative to the base port
  localparam int REG_RD_BANK = 0;
  localparam int REG_WR_BANK = 1;
  localparam int REG_CTRL    = 2;
  localparam int NUM_REGS    = 3;

endpackage

// File: rtl/swm_rst_sync.sv
module swm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/swm_port_regs.sv
module swm_port_regs
  import swm_pkg::*;
#(
  parameter int                IO_AW    = 8,
  parameter int                DATA_W   = 8,
  parameter logic [IO_AW-1:0]  BASE     = 8'h40,
  parameter logic [DATA_W-1:0] CTRL_RST = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] rd_bank,
  output logic [DATA_W-1:0] wr_bank,
  output logic              overlay_on
);

  localparam int FLAT_W = NUM_REGS * DATA_W;

  logic [NUM_REGS-1:0] hit;
  logic [FLAT_W-1:0]   regs_flat;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_VAL = (i == REG_CTRL) ? CTRL_RST : '0;
    logic              ld;
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] nxt;

    assign hit[i] = (io_addr == IO_AW'(int'(BASE) + i));

    always_comb begin
      ld  = io_wr & hit[i];
      nxt = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST_VAL;
      else if (ld) q <= nxt;
    end

    assign regs_flat[i*DATA_W +: DATA_W] = q;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (io_rd && hit[i]) rdata = regs_flat[i*DATA_W +: DATA_W];
    end
  end

  assign rd_bank    = regs_flat[REG_RD_BANK*DATA_W +: DATA_W];
  assign wr_bank    = regs_flat[REG_WR_BANK*DATA_W +: DATA_W];
  assign overlay_on = regs_flat[REG_CTRL*DATA_W];

endmodule

// File: rtl/swm_xlate.sv
module swm_xlate
  import swm_pkg::*;
#(
  parameter int CPU_AW   = 16,
  parameter int WIN_BITS = 12,
  parameter int BANK_W   = 8
) (
  input  logic [CPU_AW-1:0]          cpu_addr,
  input  logic                       is_wr,
  input  logic [BANK_W-1:0]          rd_bank,
  input  logic [BANK_W-1:0]          wr_bank,
  input  logic                       overlay_on,
  output logic [BANK_W+WIN_BITS-1:0] ext_addr,
  output tgt_e                       tgt
);

  localparam int EXT_AW = BANK_W + WIN_BITS;
  localparam int PAGE_W = CPU_AW - WIN_BITS;
  localparam int PAD_W  = EXT_AW - CPU_AW - 1;
  localparam logic [PAGE_W-1:0] WIN_PAGE = '1;

  logic              in_win;
  logic [BANK_W-1:0] bank;

  always_comb begin
    in_win = (cpu_addr[CPU_AW-1:WIN_BITS] == WIN_PAGE);
    bank   = is_wr ? wr_bank : rd_bank;
    if (in_win) begin
      ext_addr = {bank, cpu_addr[WIN_BITS-1:0]};
      tgt      = ext_addr[EXT_AW-1] ? TGT_NVM : TGT_VRAM;
    end else if (overlay_on && !is_wr) begin
      ext_addr = {1'b1, {PAD_W{1'b0}}, cpu_addr};
      tgt      = TGT_NVM;
    end else begin
      ext_addr = {1'b0, {PAD_W{1'b0}}, cpu_addr};
      tgt      = TGT_RAM;
    end
  end

endmodule

// File: rtl/swm_cs_decode.sv
module swm_cs_decode
  import swm_pkg::*;
(
  input  tgt_e tgt,
  input  logic mem_active,
  output logic ram_sel,
  output logic vram_sel,
  output logic nvm_sel
);

  tgt_e eff;

  always_comb begin
    eff      = mem_active ? tgt : TGT_NONE;
    ram_sel  = (eff == TGT_RAM);
    vram_sel = (eff == TGT_VRAM);
    nvm_sel  = (eff == TGT_NVM);
  end

endmodule

// File: rtl/split_window_mapper.sv
module split_window_mapper
  import swm_pkg::*;
#(
  parameter int                CPU_AW   = 16,
  parameter int                WIN_BITS = 12,
  parameter int                DATA_W   = 8,
  parameter int                IO_AW    = 8,
  parameter logic [IO_AW-1:0]  IO_BASE  = 8'h40,
  parameter int                SYNC_STG = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [CPU_AW-1:0]            cpu_addr,
  input  logic                         mreq_n,
  input  logic                         iorq_n,
  input  logic                         rd_n,
  input  logic                         wr_n,
  input  logic [DATA_W-1:0]            data_in,
  output logic [DATA_W-1:0]            data_out,
  output logic [DATA_W+WIN_BITS-1:0]   ext_addr,
  output logic                         ram_sel,
  output logic                         vram_sel,
  output logic                         nvm_sel
);

  localparam int BANK_W = DATA_W;

  logic              rst_q_n;
  logic              io_wr_stb;
  logic              io_rd_stb;
  logic              mem_active;
  logic              is_wr;
  logic [BANK_W-1:0] rd_bank;
  logic [BANK_W-1:0] wr_bank;
  logic              overlay_on;
  tgt_e              tgt;

  always_comb begin
    io_wr_stb  = !iorq_n && !wr_n;
    io_rd_stb  = !iorq_n && !rd_n;
    mem_active = !mreq_n && (!rd_n || !wr_n);
    is_wr      = !wr_n;
  end

  swm_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  swm_port_regs #(
    .IO_AW  (IO_AW),
    .DATA_W (DATA_W),
    .BASE   (IO_BASE)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .io_addr    (cpu_addr[IO_AW-1:0]),
    .io_wr      (io_wr_stb),
    .io_rd      (io_rd_stb),
    .wdata      (data_in),
    .rdata      (data_out),
    .rd_bank    (rd_bank),
    .wr_bank    (wr_bank),
    .overlay_on (overlay_on)
  );

  swm_xlate #(
    .CPU_AW   (CPU_AW),
    .WIN_BITS (WIN_BITS),
    .BANK_W   (BANK_W)
  ) u_xlate (
    .cpu_addr   (cpu_addr),
    .is_wr      (is_wr),
    .rd_bank    (rd_bank),
    .wr_bank    (wr_bank),
    .overlay_on (overlay_on),
    .ext_addr   (ext_addr),
    .tgt        (tgt)
  );

  swm_cs_decode u_cs (
    .tgt        (tgt),
    .mem_active (mem_active),
    .ram_sel    (ram_sel),
    .vram_sel   (vram_sel),
    .nvm_sel    (nvm_sel)
  );

endmodule

// File: rtl/swm_checker.sv
module swm_checker #(
  parameter int               CPU_AW   = 16,
  parameter int               WIN_BITS = 12,
  parameter int               EXT_AW   = 20,
  parameter int               DATA_W   = 8,
  parameter int               IO_AW    = 8,
  parameter logic [IO_AW-1:0] IO_BASE  = 8'h40
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CPU_AW-1:0] cpu_addr,
  input logic              mreq_n,
  input logic              iorq_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic [DATA_W-1:0] data_in,
  input logic [EXT_AW-1:0] ext_addr,
  input logic              ram_sel,
  input logic              vram_sel,
  input logic              nvm_sel,
  input logic              overlay_on
);

  logic win, any_sel, mem_rd, mem_wr, io_wr;
  assign win     = &cpu_addr[CPU_AW-1:WIN_BITS];
  assign any_sel = ram_sel | vram_sel | nvm_sel;
  assign mem_rd  = !mreq_n && !rd_n && wr_n;
  assign mem_wr  = !mreq_n && !wr_n;
  assign io_wr   = !iorq_n && !wr_n;

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({ram_sel, vram_sel, nvm_sel})); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (mreq_n || (rd_n && wr_n)) |-> !any_sel); // R10
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n) (win && any_sel) |-> (ext_addr[WIN_BITS-1:0] == cpu_addr[WIN_BITS-1:0])); // R1
  AST_WIN_TARGET: assert property (@(posedge clk) disable iff (!rst_n) (win && any_sel) |-> (nvm_sel == ext_addr[EXT_AW-1])); // R4
  AST_RBANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (io_wr && cpu_addr[IO_AW-1:0] == IO_BASE) |=> (!(win && mem_rd) || ext_addr[EXT_AW-1:WIN_BITS] == $past(data_in))); // R2
  AST_OVL_WRITE_RAM: assert property (@(posedge clk) disable iff (!rst_n) (overlay_on && mem_wr && !win) |-> ram_sel); // R7
  AST_OVL_READ_NVM: assert property (@(posedge clk) disable iff (!rst_n) (overlay_on && mem_rd && !win) |-> nvm_sel); // R6
  AST_OVL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (io_wr && cpu_addr[IO_AW-1:0] == IO_AW'(int'(IO_BASE) + 2) && !data_in[0]) |=> !overlay_on); // R8

endmodule

bind split_window_mapper swm_checker #(
  .CPU_AW   (CPU_AW),
  .WIN_BITS (WIN_BITS),
  .EXT_AW   (DATA_W + WIN_BITS),
  .DATA_W   (DATA_W),
  .IO_AW    (IO_AW),
  .IO_BASE  (IO_BASE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .cpu_addr   (cpu_addr),
  .mreq_n     (mreq_n),
  .iorq_n     (iorq_n),
  .rd_n       (rd_n),
  .wr_n       (wr_n),
  .data_in    (data_in),
  .ext_addr   (ext_addr),
  .ram_sel    (ram_sel),
  .vram_sel   (vram_sel),
  .nvm_sel    (nvm_sel),
  .overlay_on (overlay_on)
);

// File: tb/tb_split_window_mapper.sv
module tb_split_window_mapper;

  logic        clk;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        mreq_n, iorq_n, rd_n, wr_n;
  logic [7:0]  data_in;
  logic [7:0]  data_out;
  logic [19:0] ext_addr;
  logic        ram_sel, vram_sel, nvm_sel;

  int errors = 0;
  int checks = 0;

  split_window_mapper dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mreq_n(mreq_n),
    .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .data_in(data_in),
    .data_out(data_out), .ext_addr(ext_addr), .ram_sel(ram_sel),
    .vram_sel(vram_sel), .nvm_sel(nvm_sel)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // vector: addr[39:24] wr[23] ext[22:3] sel{ram,vram,nvm}[2:0]
  // read bank 0x12, write bank 0x85, overlay off
  localparam logic [39:0] VEC [8] = '{
    {16'hF123, 1'b0, 20'h12123, 3'b010},
    {16'hFABC, 1'b1, 20'h85ABC, 3'b001},
    {16'h0000, 1'b0, 20'h00000, 3'b100},
    {16'hEFFF, 1'b1, 20'h0EFFF, 3'b100},
    {16'h7FFF, 1'b0, 20'h07FFF, 3'b100},
    {16'hFFFF, 1'b0, 20'h12FFF, 3'b010},
    {16'hF000, 1'b1, 20'h85000, 3'b001},
    {16'h1234, 1'b1, 20'h01234, 3'b100}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    mreq_n = 1'b1; iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic io_write(input logic [7:0] port, input logic [7:0] val);
    @(negedge clk);
    cpu_addr = {8'h00, port}; data_in = val; iorq_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    idle();
  endtask

  task automatic io_read_chk(input string req, input logic [7:0] port, input logic [7:0] exp);
    @(negedge clk);
    cpu_addr = {8'h00, port}; iorq_n = 1'b0; rd_n = 1'b0;
    #1 check(req, {24'h0, data_out}, {24'h0, exp});
    idle();
  endtask

  task automatic mem_chk(input string req, input logic [15:0] a, input logic w,
                         input logic [19:0] exp_ext, input logic [2:0] exp_sel);
    @(negedge clk);
    cpu_addr = a; mreq_n = 1'b0;
    if (w) wr_n = 1'b0; else rd_n = 1'b0;
    #1;
    check(req, {12'h0, ext_addr}, {12'h0, exp_ext});
    check(req, {29'h0, ram_sel, vram_sel, nvm_sel}, {29'h0, exp_sel});
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle();
    cpu_addr = '0; data_in = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset values and read-back ports
    io_read_chk("R9 rd bank reset", 8'h40, 8'h00);
    io_read_chk("R9 wr bank reset", 8'h41, 8'h00);
    io_read_chk("R9 ctrl reset", 8'h42, 8'h01);
    @(negedge clk); #1 check("R9 data_out idle", {24'h0, data_out}, 32'h0);
    check("R10 idle no select", {29'h0, ram_sel, vram_sel, nvm_sel}, 32'h0);

    // R6 / R7 / R11 overlay behaviour after reset
    mem_chk("R6 overlay read", 16'h0100, 1'b0, 20'h80100, 3'b001);
    mem_chk("R7 overlay write", 16'h0100, 1'b1, 20'h00100, 3'b100);
    mem_chk("R11 window under overlay", 16'hF010, 1'b0, 20'h00010, 3'b010);

    // program banks, R12 neighbour port ignored
    io_write(8'h40, 8'h12);
    io_write(8'h41, 8'h85);
    io_write(8'h43, 8'hFF);
    io_write(8'h3F, 8'h00);
    io_read_chk("R9 rd bank readback", 8'h40, 8'h12);
    io_read_chk("R9 wr bank readback", 8'h41, 8'h85);
    io_read_chk("R12 ctrl untouched", 8'h42, 8'h01);
    io_read_chk("R12 port 0x43 reads zero", 8'h43, 8'h00);
    mem_chk("R12 overlay still on", 16'h0200, 1'b0, 20'h80200, 3'b001);

    // R8 clear overlay
    io_write(8'h42, 8'h00);
    io_read_chk("R8 ctrl cleared", 8'h42, 8'h00);
    mem_chk("R8 R5 ram after clear", 16'h0100, 1'b0, 20'h00100, 3'b100);

    // table walk: R1 R2 R3 R4 R5
    for (int i = 0; i < 8; i++) begin
      mem_chk("R1-table R2 R3 R4 R5", VEC[i][39:24], VEC[i][23], VEC[i][22:3], VEC[i][2:0]);
    end

    // R4 bank boundary
    io_write(8'h40, 8'h7F);
    mem_chk("R4 last vram bank", 16'hFFFF, 1'b0, 20'h7FFFF, 3'b010);
    io_write(8'h40, 8'h80);
    mem_chk("R4 first nvm bank", 16'hF000, 1'b0, 20'h80000, 3'b001);
    mem_chk("R3 write bank kept", 16'hF001, 1'b1, 20'h85001, 3'b001);

    // R8 re-enable
    io_write(8'h42, 8'h01);
    mem_chk("R8 overlay re-enabled", 16'h2000, 1'b0, 20'h82000, 3'b001);

    // R10 no select without strobes or on I/O cycle
    @(negedge clk);
    cpu_addr = 16'hF000; mreq_n = 1'b0;
    #1 check("R10 mreq without rd/wr", {29'h0, ram_sel, vram_sel, nvm_sel}, 32'h0);
    idle();
    @(negedge clk);
    cpu_addr = 16'hF040; iorq_n = 1'b0; rd_n = 1'b0;
    #1 check("R10 io cycle no select", {29'h0, ram_sel, vram_sel, nvm_sel}, 32'h0);
    idle();

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule